// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers level requests from 32 primary sources and from a group of secondary sources, and presents them to a processor on two lines: a normal interrupt and a fast interrupt. The secondary sources are organised in groups. Each group has its own pending and mask bits and folds into one primary source. Every primary source has a pending bit, a mask bit, a mode bit and a 2-bit priority level. Software reaches all of these through a small register bus with a combinational read path. Pending and in-service bits are cleared by writing 1 to them.

Exactly one source can be steered to the fast line. That line follows the source's unmasked pending state directly and does not use the in-service register. All other unmasked pending sources compete in a priority arbiter. The winner is latched into a one-hot in-service register, and its number goes into an index register. The normal line is then raised and stays high until software clears the in-service bit. The index returns to zero when that happens.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset both mask registers (primary at address 3, secondary at address 1) read all ones. The pending, in-service, mode, level and index registers read zero, and both irq_o and fiq_o are low.
- R2: A high secondary request bit at a clock edge sets its bit in the secondary pending register (address 1 is the mask, address 0 the pending register). The bit stays set after the request drops, until a 1 is written to it at address 0.
- R3: A pending secondary bit j whose secondary mask bit is 0 sets primary pending bit 28 + j/3 one clock later. A secondary bit whose mask bit is 1 sets nothing in the primary stage.
- R4: A high primary request bit at a clock edge sets its bit in the primary pending register (address 2). Writing 1 to that bit clears it in that cycle. Writing 0 leaves it unchanged. A request that is still high sets the bit again at the next edge.
- R5: The mode register (address 4) holds one bit per source, where 1 means fast. A write with more than one bit set is ignored, so at most one source is ever in fast mode.
- R6: fiq_o is high exactly while the fast-mode source is pending and unmasked. That source never enters arbitration, the in-service register or irq_o.
- R7: Among pending, unmasked, normal-mode sources, the one with the highest level wins, and on equal levels the lower number wins. Source i's level is bits [2*(i%16)+1 : 2*(i%16)] of level word 8 + i/16. The winner alone is set in the in-service register (address 5), and its number appears in the index register (address 6).
- R8: irq_o is high while any in-service bit is set. While an in-service bit is set, the in-service and index registers do not change unless software writes the in-service register.
- R9: Writing 1 to the set in-service bit clears it and returns the index to zero in the same cycle. A still-pending candidate is latched at the following edge.
- R10: A source whose primary mask bit is 1 drives neither irq_o nor fiq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NUM_SRC | Primary level requests, active high |
| sub_req | input | SUB_GRPS*SUB_PER_GRP | Secondary level requests, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Some properties are checked by assertions on every cycle. At most one mode bit and at most one in-service bit are ever set. The in-service and index registers stay frozen until software writes the in-service register, and the index is zero whenever nothing is in service. A rise of irq_o always has an eligible candidate in the cycle before. Pending bits fall only under a clear write. The bench scenarios cover what the assertions cannot show: the level-then-index ordering of winners, the one-cycle delay of the secondary fold and which group it lands in, the rejection of a multi-bit mode write, fast-line bypass and masking, and the re-arming of a pending bit after a clear while its request is held.

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl #(
  parameter int NUM_SRC     = 32,
  parameter int SUB_GRPS    = 4,
  parameter int SUB_PER_GRP = 3,
  parameter int SUB_BASE    = 28,
  parameter int DW          = 32,
  parameter int AW          = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              src_req,
  input  logic [SUB_GRPS*SUB_PER_GRP-1:0] sub_req,
  input  logic                            bus_we,
  input  logic [AW-1:0]                   bus_addr,
  input  logic [DW-1:0]                   bus_wdata,
  output logic [DW-1:0]                   bus_rdata,
  output logic                            irq_o,
  output logic                            fiq_o
);
  localparam int NSUB = SUB_GRPS * SUB_PER_GRP;
  localparam int LPW  = DW / 2;
  localparam int LVLW = (NUM_SRC + LPW - 1) / LPW;
  localparam int IW   = $clog2(NUM_SRC);

  localparam logic [AW-1:0] A_SUBPEND = AW'(0);
  localparam logic [AW-1:0] A_SUBMASK = AW'(1);
  localparam logic [AW-1:0] A_PEND    = AW'(2);
  localparam logic [AW-1:0] A_MASK    = AW'(3);
  localparam logic [AW-1:0] A_MODE    = AW'(4);
  localparam logic [AW-1:0] A_INSERV  = AW'(5);
  localparam logic [AW-1:0] A_INDEX   = AW'(6);
  localparam int            A_LVL     = 8;

  logic [NSUB-1:0]    subpend_q, submask_q;
  logic [NUM_SRC-1:0] pend_q, mask_q, mode_q, inserv_q;
  logic [IW-1:0]      index_q;
  logic [1:0]         lvl_q [NUM_SRC];

  wire wr_subpend = bus_we && bus_addr == A_SUBPEND;
  wire wr_submask = bus_we && bus_addr == A_SUBMASK;
  wire wr_pend    = bus_we && bus_addr == A_PEND;
  wire wr_mask    = bus_we && bus_addr == A_MASK;
  wire wr_mode    = bus_we && bus_addr == A_MODE;
  wire wr_inserv  = bus_we && bus_addr == A_INSERV;

  wire [NSUB-1:0]    clr_sub  = wr_subpend ? bus_wdata[NSUB-1:0] : '0;
  wire [NUM_SRC-1:0] clr_pend = wr_pend ? bus_wdata[NUM_SRC-1:0] : '0;
  wire [NUM_SRC-1:0] clr_ins  = wr_inserv ? bus_wdata[NUM_SRC-1:0] : '0;
  wire [NUM_SRC-1:0] ins_left = inserv_q & ~clr_ins;
  wire [NUM_SRC-1:0] cand     = pend_q & ~mask_q & ~mode_q;

  logic [NUM_SRC-1:0] sub_fold;
  always_comb begin
    sub_fold = '0;
    for (int g = 0; g < SUB_GRPS; g++)
      sub_fold[SUB_BASE+g] = |(subpend_q[g*SUB_PER_GRP +: SUB_PER_GRP] &
                              ~submask_q[g*SUB_PER_GRP +: SUB_PER_GRP]);
  end

  logic          win_found;
  logic [IW-1:0] win_idx;
  logic [1:0]    win_lvl;
  always_comb begin
    win_found = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (cand[i] && (!win_found || lvl_q[i] > win_lvl)) begin
        win_found = 1'b1;
        win_idx   = IW'(i);
        win_lvl   = lvl_q[i];
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      subpend_q <= '0;
      submask_q <= '1;
      pend_q    <= '0;
      mask_q    <= '1;
      mode_q    <= '0;
      inserv_q  <= '0;
      index_q   <= '0;
      for (int i = 0; i < NUM_SRC; i++) lvl_q[i] <= '0;
    end else begin
      subpend_q <= (subpend_q | sub_req) & ~clr_sub;
      pend_q    <= (pend_q | src_req | sub_fold) & ~clr_pend;
      if (wr_submask) submask_q <= bus_wdata[NSUB-1:0];
      if (wr_mask)    mask_q    <= bus_wdata[NUM_SRC-1:0];
      if (wr_mode && $countones(bus_wdata[NUM_SRC-1:0]) <= 1)
        mode_q <= bus_wdata[NUM_SRC-1:0];
      for (int i = 0; i < NUM_SRC; i++)
        if (bus_we && bus_addr == AW'(A_LVL + i / LPW))
          lvl_q[i] <= bus_wdata[2*(i%LPW) +: 2];
      if (inserv_q == '0) begin
        if (win_found) begin
          inserv_q <= NUM_SRC'(1) << win_idx;
          index_q  <= win_idx;
        end
      end else begin
        inserv_q <= ins_left;
        if (ins_left == '0) index_q <= '0;
      end
    end
  end

  assign irq_o = |inserv_q;
  assign fiq_o = |(pend_q & ~mask_q & mode_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_SUBPEND: bus_rdata = DW'(subpend_q);
      A_SUBMASK: bus_rdata = DW'(submask_q);
      A_PEND:    bus_rdata = DW'(pend_q);
      A_MASK:    bus_rdata = DW'(mask_q);
      A_MODE:    bus_rdata = DW'(mode_q);
      A_INSERV:  bus_rdata = DW'(inserv_q);
      A_INDEX:   bus_rdata = DW'(index_q);
      default:
        for (int i = 0; i < NUM_SRC; i++)
          if (bus_addr == AW'(A_LVL + i / LPW))
            bus_rdata[2*(i%LPW) +: 2] = lvl_q[i];
    endcase
  end

  a_r5_mode_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mode_q));

  a_r7_one_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inserv_q));

  a_r8_hold_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    (inserv_q != '0 && !wr_inserv) |=> ($stable(inserv_q) && $stable(index_q)));

  a_r9_index_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (inserv_q == '0) |-> (index_q == '0));

  a_r6_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(cand != '0));

  a_r4_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pend |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: tb/irq_cascade_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_cascade_ctrl_tb_top;
  localparam logic [3:0] A_SUBPEND = 4'd0, A_SUBMASK = 4'd1, A_PEND = 4'd2,
                         A_MASK = 4'd3, A_MODE = 4'd4, A_INSERV = 4'd5,
                         A_INDEX = 4'd6, A_LVL0 = 4'd8, A_LVL1 = 4'd9;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src_req;
  logic [11:0] sub_req;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_o, fiq_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_cascade_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .sub_req(sub_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rchk(input string req, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    rchk("R1 primary mask", A_MASK, 32'hFFFF_FFFF);
    rchk("R1 secondary mask", A_SUBMASK, 32'h0000_0FFF);
    rchk("R1 pending", A_PEND, 32'h0);
    rchk("R1 mode", A_MODE, 32'h0);
    rchk("R1 index", A_INDEX, 32'h0);
    rchk("R1 level word", A_LVL1, 32'h0);
    chk("R1 irq low", {31'h0, irq_o}, 32'h0);
    chk("R1 fiq low", {31'h0, fiq_o}, 32'h0);
  endtask

  task automatic t_primary;
    src_req[5] = 1'b1; step(1); src_req[5] = 1'b0;
    rchk("R4 request sets pending", A_PEND, 32'h20);
    step(1);
    rchk("R4 pending sticky", A_PEND, 32'h20);
    chk("R10 masked source no irq", {31'h0, irq_o}, 32'h0);
    wr(A_PEND, 32'h0);
    rchk("R4 write zero no effect", A_PEND, 32'h20);
    wr(A_MASK, ~32'h20);
    step(1);
    chk("R8 irq raised", {31'h0, irq_o}, 32'h1);
    rchk("R7 index of winner", A_INDEX, 32'd5);
    rchk("R7 in-service one-hot", A_INSERV, 32'h20);
    wr(A_PEND, 32'h20);
    rchk("R4 clear pending", A_PEND, 32'h0);
    chk("R8 irq held until in-service cleared", {31'h0, irq_o}, 32'h1);
    wr(A_INSERV, 32'h20);
    chk("R9 irq drops", {31'h0, irq_o}, 32'h0);
    rchk("R9 index back to zero", A_INDEX, 32'h0);
  endtask

  task automatic t_reassert;
    wr(A_MASK, ~32'h80);
    src_req[7] = 1'b1; step(1);
    rchk("R4 held request pending", A_PEND, 32'h80);
    wr(A_PEND, 32'h80);
    rchk("R4 clear wins in clear cycle", A_PEND, 32'h0);
    step(1);
    rchk("R4 held request re-sets", A_PEND, 32'h80);
    src_req[7] = 1'b0;
    wr(A_PEND, 32'h80);
    wr(A_INSERV, 32'h80);
    step(1);
    chk("R9 idle after cleanup", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_priority;
    wr(A_MASK, ~32'h0010_0208);
    src_req = 32'h0010_0208; step(1); src_req = '0;
    step(1);
    rchk("R7 equal levels lowest index", A_INDEX, 32'd3);
    step(3);
    rchk("R8 winner held while in service", A_INDEX, 32'd3);
    rchk("R8 in-service held", A_INSERV, 32'h8);
    wr(A_PEND, 32'h8);
    wr(A_INSERV, 32'h8);
    rchk("R9 index zero after clear", A_INDEX, 32'h0);
    step(1);
    rchk("R9 next candidate latched", A_INDEX, 32'd9);
    wr(A_LVL1, 32'h200);
    rchk("R7 level field readback", A_LVL1, 32'h200);
    wr(A_INSERV, 32'h200);
    step(1);
    rchk("R7 higher level beats lower index", A_INDEX, 32'd20);
    wr(A_LVL0, 32'h0008_0000);
    wr(A_INSERV, 32'h0010_0000);
    step(1);
    rchk("R7 tie at level 2 lower index", A_INDEX, 32'd9);
    wr(A_PEND, 32'h0010_0200);
    wr(A_INSERV, 32'h200);
    wr(A_LVL0, 32'h0); wr(A_LVL1, 32'h0);
    wr(A_MASK, 32'hFFFF_FFFF);
    step(1);
    chk("R8 irq low when nothing in service", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_secondary;
    wr(A_MASK, 32'hCFFF_FFFF);
    wr(A_SUBMASK, 32'hFFD);
    sub_req = 12'h012; step(1); sub_req = '0;
    rchk("R2 secondary pending set", A_SUBPEND, 32'h12);
    rchk("R3 fold not yet visible", A_PEND, 32'h0);
    step(1);
    rchk("R3 unmasked secondary folds, masked does not", A_PEND, 32'h1000_0000);
    step(1);
    rchk("R3 folded source wins", A_INDEX, 32'd28);
    rchk("R2 secondary pending sticky", A_SUBPEND, 32'h12);
    wr(A_SUBPEND, 32'h12);
    rchk("R2 secondary write-one clear", A_SUBPEND, 32'h0);
    wr(A_PEND, 32'h1000_0000);
    wr(A_INSERV, 32'h1000_0000);
    wr(A_MASK, 32'hFFFF_FFFF);
    wr(A_SUBMASK, 32'hFFF);
    chk("R9 irq low after secondary cleanup", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_fast;
    wr(A_MASK, ~32'h3000);
    wr(A_MODE, 32'h1000);
    wr(A_MODE, 32'h3000);
    rchk("R5 multi-bit mode write ignored", A_MODE, 32'h1000);
    src_req[12] = 1'b1; step(1); src_req[12] = 1'b0;
    chk("R6 fiq follows pending fast source", {31'h0, fiq_o}, 32'h1);
    step(2);
    chk("R6 fast source no irq", {31'h0, irq_o}, 32'h0);
    rchk("R6 fast source not in service", A_INSERV, 32'h0);
    wr(A_MASK, 32'hFFFF_FFFF);
    chk("R10 masked fast source no fiq", {31'h0, fiq_o}, 32'h0);
    wr(A_PEND, 32'h1000);
    wr(A_MODE, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; src_req = '0; sub_req = '0;
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_primary();
    t_reassert();
    t_priority();
    t_secondary();
    t_fast();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1..all actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule